// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns a digital supply-low indication into the reset and status signals a microprocessor system needs. The supply-low flag comes from an external threshold comparator and is brought into the system clock domain by a two-flop synchronizer. While the flag is set, the block holds reset asserted, drives its low-line status output low and blocks the memory chip-enable. Once the flag clears, reset stays asserted for a stretch of time-base ticks, so the supply and the processor clock can settle before the processor runs.

A watchdog timer elsewhere in the system can ask for a reset. That request produces a reset pulse with the same stretch. The stretch is counted in ticks of a time-base enable, either 512 or 2048 ticks. The choice is sampled when each stretch begins. A one-cycle done pulse marks the end of every stretch, so the watchdog timer can restart from a known point.

Top module: `supply_rst_seq`

## Requirements
- R1: Two clock edges after `supply_low_raw` goes high, `rst_out_n` is 0. It stays 0 while the synchronized flag is set and through the whole stretch that follows.
- R2: A `wdog_req` high at a clock edge while reset is inactive drives `rst_out_n` to 0 after that edge, and the pulse releases after the stretch. The release comes at the edge of the stretch's last tick, that is N+1 edges counted from the request edge when tick is always 1. A request while reset is already active has no effect.
- R3: The stretch is N=512 ticks when `long_sel` is 0 and N=2048 ticks when it is 1. `long_sel` is sampled once when the stretch starts, and later changes do not alter it. With tick always 1, `rst_out_n` rises at the (N+3)-th edge after `supply_low_raw` falls.
- R4: `low_line_n` is the inverse of the synchronized supply flag, with no stretch. It goes to 0 two edges after the flag rises and back to 1 two edges after it falls, even while reset is still being held.
- R5: `rst_out` is always the exact complement of `rst_out_n`.
- R6: `ce_out_n` equals `ce_in_n` (a combinational path) while the synchronized flag is clear, and is 1 while the flag is set.
- R7: While the synchronized flag is set, `wdog_req`, `long_sel` and `ce_in_n` have no effect on the outputs or on the next stretch.
- R8: If the flag sets again during a stretch, the tick count clears, and a full new stretch starts only after the flag clears again.
- R9: `rst_done` is 1 for exactly one cycle, in the cycle in which `rst_out_n` first reads 1 after a stretch.
- R10: Only cycles with `tick` high advance the stretch. With `tick` held at 0, reset stays asserted indefinitely.
- R11: While `rst_n` is 0, the block behaves as if the supply is low: `rst_out_n`=0, `low_line_n`=0, `ce_out_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| supply_low_raw | input | 1 | Asynchronous supply-low flag from the comparator |
| wdog_req | input | 1 | Watchdog timeout request |
| tick | input | 1 | Time-base enable, one clock wide |
| long_sel | input | 1 | 1 selects the 2048-tick stretch, 0 the 512-tick stretch |
| ce_in_n | input | 1 | Chip-enable from the processor, active low |
| rst_out_n | output | 1 | Reset, active low |
| rst_out | output | 1 | Reset, active high |
| low_line_n | output | 1 | Unstretched supply-good status |
| ce_out_n | output | 1 | Gated chip-enable, active low |
| rst_done | output | 1 | One-cycle end-of-stretch pulse |

## Verification
The bench measures the exact edge count of every stretch from its cause, for both widths and for both causes. A design that counted the width off by one, or that used the select value after the stretch began, would show a shifted count. The bench drops the supply again in the middle of a stretch. A design that kept its partial count would release early. It also sends watchdog requests during a stretch and during the low phase, where a wrong design would lengthen the pulse or add a second one. Holding the tick low for thousands of cycles exposes a counter that runs on every clock.

// File: rtl/supply_rst_seq.sv
module supply_rst_seq #(
  parameter int SHORT_TICKS = 512,
  parameter int LONG_TICKS  = 2048,
  localparam int CW = $clog2(LONG_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low_raw,
  input  logic wdog_req,
  input  logic tick,
  input  logic long_sel,
  input  logic ce_in_n,
  output logic rst_out_n,
  output logic rst_out,
  output logic low_line_n,
  output logic ce_out_n,
  output logic rst_done
);

  logic [1:0]    sync_q;
  logic          sup_low_s;
  logic          sup_prev_q;
  logic          hold_q;
  logic          lim_long_q;
  logic          done_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_val;

  assign sup_low_s = sync_q[1];
  assign lim_val   = lim_long_q ? CW'(LONG_TICKS) : CW'(SHORT_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= 2'b11;
      sup_prev_q <= 1'b1;
      hold_q     <= 1'b1;
      lim_long_q <= 1'b0;
      cnt_q      <= '0;
      done_q     <= 1'b0;
    end else begin
      sync_q     <= {sync_q[0], supply_low_raw};
      sup_prev_q <= sup_low_s;
      done_q     <= 1'b0;
      if (sup_low_s) begin
        hold_q <= 1'b1;
        cnt_q  <= '0;
      end else if (sup_prev_q) begin
        lim_long_q <= long_sel;
        cnt_q      <= '0;
      end else if (!hold_q) begin
        if (wdog_req) begin
          hold_q     <= 1'b1;
          cnt_q      <= '0;
          lim_long_q <= long_sel;
        end
      end else if (tick) begin
        if (cnt_q == lim_val - CW'(1)) begin
          hold_q <= 1'b0;
          cnt_q  <= '0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign rst_out_n  = ~(hold_q | sup_low_s);
  assign rst_out    = ~rst_out_n;
  assign low_line_n = ~sup_low_s;
  assign ce_out_n   = ce_in_n | sup_low_s;
  assign rst_done   = done_q;

  a_r5_complement: assert property (@(posedge clk) rst_out != rst_out_n);

  a_r1_low_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
    sup_low_s |-> !rst_out_n);

  a_r6_ce_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    sup_low_s |-> ce_out_n);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done |=> !rst_done);

  a_r9_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done |-> rst_out_n);

  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sup_low_s |=> cnt_q == '0);

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < lim_val);

  a_r2_wdog_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out_n && !sup_prev_q && wdog_req) |=> !rst_out_n);

endmodule

// File: tb/supply_rst_seq_tb_top.sv
module supply_rst_seq_tb_top;
  localparam int NS = 512;
  localparam int NL = 2048;

  logic clk = 0, rst_n = 0, supply_low_raw = 1, wdog_req = 0, tick = 1;
  logic long_sel = 0, ce_in_n = 1;
  logic rst_out_n, rst_out, low_line_n, ce_out_n, rst_done;

  int total = 0, bad = 0, edges = 0;
  int exp_q[$];
  string tag_q[$];
  bit done_next = 0;

  always #4 clk = ~clk;

  supply_rst_seq dut_i (
    .clk(clk), .rst_n(rst_n), .supply_low_raw(supply_low_raw), .wdog_req(wdog_req),
    .tick(tick), .long_sel(long_sel), .ce_in_n(ce_in_n), .rst_out_n(rst_out_n),
    .rst_out(rst_out), .low_line_n(low_line_n), .ce_out_n(ce_out_n), .rst_done(rst_done));

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(string tag, int n);
    edges = 0;
    exp_q.push_back(n);
    tag_q.push_back(tag);
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    cyc(3);
  endtask

  always @(posedge clk) edges++;

  // monitor: pops expected stretch length at every release
  initial begin
    logic prev = 0;
    forever begin
      @(posedge clk); #2;
      if (done_next) begin
        chk("R9 done one cycle", rst_done, 0);
        done_next = 0;
      end
      chk("R5 complement", rst_out, !rst_out_n);
      if (!prev && rst_out_n && rst_n) begin
        if (exp_q.size() == 0) chk("R2 unexpected release", 1, 0);
        else begin
          int e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk(t, edges, e);
        end
        chk("R9 done at release", rst_done, 1);
        done_next = 1;
      end
      prev = rst_out_n;
    end
  end

  initial begin
    cyc(150000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R11 reset rst_out_n", rst_out_n, 0);
    chk("R11 reset low_line_n", low_line_n, 0);
    chk("R11 reset ce_out_n", ce_out_n, 1);
    rst_n = 1;
    cyc(2);
    supply_low_raw = 0; push("R3 power-up short", NS + 3);
    cyc(2);
    chk("R4 low_line clears unstretched", low_line_n, 1);
    chk("R1 reset held in stretch", rst_out_n, 0);
    drain();
    ce_in_n = 0; #1;
    chk("R6 ce follows 0", ce_out_n, 0);
    ce_in_n = 1; #1;
    chk("R6 ce follows 1", ce_out_n, 1);
    ce_in_n = 0;

    // long stretch after a supply dip
    long_sel = 1; supply_low_raw = 1;
    cyc(2);
    chk("R4 low_line sets", low_line_n, 0);
    chk("R1 reset on low", rst_out_n, 0);
    chk("R6 ce blocked", ce_out_n, 1);
    supply_low_raw = 0; push("R3 long stretch", NL + 3);
    drain();

    long_sel = 0;
    wdog_req = 1; push("R2 watchdog short", NS + 1);
    cyc(1); wdog_req = 0;
    drain();
    long_sel = 1;
    wdog_req = 1; push("R2 watchdog long", NL + 1);
    cyc(1); wdog_req = 0;
    drain();

    // R7: inputs ignored while low
    supply_low_raw = 1; cyc(3);
    long_sel = 1; wdog_req = 1; ce_in_n = 1; cyc(2);
    ce_in_n = 0; cyc(1);
    chk("R7 ce ignored while low", ce_out_n, 1);
    chk("R7 low_line while low", low_line_n, 0);
    wdog_req = 0; long_sel = 0;
    supply_low_raw = 0; push("R7 select ignored while low", NS + 3);
    drain();
    cyc(20);
    chk("R7 no extra pulse from request", rst_out_n, 1);

    // R8 restart mid-stretch
    supply_low_raw = 1; cyc(4);
    supply_low_raw = 0; cyc(100);
    supply_low_raw = 1; cyc(5);
    supply_low_raw = 0; push("R8 restart full stretch", NS + 3);
    drain();

    // R3/R2 changes during stretch ignored
    long_sel = 0;
    wdog_req = 1; push("R3 select fixed at start", NS + 1);
    cyc(1); wdog_req = 0;
    cyc(50);
    long_sel = 1; wdog_req = 1;
    cyc(1); wdog_req = 0; long_sel = 0;
    drain();

    // R10 tick gating
    tick = 0; supply_low_raw = 1; cyc(4);
    supply_low_raw = 0; cyc(3000);
    chk("R10 no count without tick", rst_out_n, 0);
    tick = 1; push("R10 ticks counted", NS);
    drain();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule